// File: doc/BRIEF.md
# Parallel Bus Initiator Phase Controller

This block is the initiator side of an 8-bit parallel peripheral bus. The bus has wired-OR control lines, so every line has a drive output and a separate observed input. After a `start` request, the controller watches for a free bus and then arbitrates. To arbitrate it raises busy and places its own one-hot ID bit on the data lines. If no higher ID bit shows up during the arbitration window, it selects the chosen target. To select, it raises select with its own ID bit and the target's ID bit on the data lines, then releases busy and waits for the target to take busy over.

Once connected, the target sets the phase lines (control/data, message, input/output) and paces every byte with request. The initiator answers each request with an interlocked acknowledge. Received bytes appear on `rx_byte` with their phase and a parity verdict. Bytes for the target are taken from `out_data`, one per `out_take` pulse. The connection ends when the target releases busy. A bus reset line aborts any activity at once.

States: IDLE, WAIT_FREE, ARB, LOST, SEL_DRIVE, SEL_WAIT, SEL_FAIL, XFER, CAPT, ACK_IN, DRIVE, ACK_OUT, DONE. Transitions:
- IDLE→WAIT_FREE on `start`.
- WAIT_FREE→ARB after FREE_CYC consecutive free cycles.
- ARB→LOST when a higher ID bit is present at the end of the window, or when select is seen. LOST→WAIT_FREE.
- ARB→SEL_DRIVE at the end of the window when the controller wins. SEL_DRIVE→SEL_WAIT.
- SEL_WAIT→XFER when target busy is seen. SEL_WAIT→SEL_FAIL after SEL_TMO cycles. SEL_FAIL→IDLE.
- XFER→CAPT on request with input direction. CAPT→ACK_IN. ACK_IN→XFER once request drops.
- XFER→DRIVE on request with output direction. DRIVE→ACK_OUT. ACK_OUT→XFER once request drops.
- XFER→DONE when busy drops. DONE→IDLE.
- Any state→IDLE while the bus reset line is high.

Top module: `pbus_initiator`

## Requirements
- R1: While `bus_rst_in` is high, the controller is back in IDLE on the next clock and releases busy, select, acknowledge and the data lines; asynchronous `rst_n` gives the same released state.
- R2: Busy is first raised only after FREE_CYC (default 4) consecutive cycles with both observed busy and select low; a busy cycle restarts the count.
- R3: During arbitration the controller drives busy and only data bit OWN_ID (default 6, so 0x40). If a data bit above OWN_ID is set after ARB_CYC cycles (bit 7 highest priority), it withdraws, pulses `arb_lost` and retries from WAIT_FREE.
- R4: On winning, the controller drives select, busy and data = own bit OR target bit for one cycle. It then keeps select while busy is released. If target busy is not seen within SEL_TMO cycles, it pulses `sel_fail` and returns to IDLE.
- R5: One clock after target busy is seen during selection, select and the data-line drive are released.
- R6: On a request with input/output high (input), the byte on the data lines is captured and shown for one cycle with `rx_valid`. `rx_phase` = {control/data, message, input/output} (bit 2 = control/data, bit 0 = input/output).
- R7: On a request with input/output low (output), the controller latches `out_data`, pulses `out_take`, drives the byte with odd parity, and raises acknowledge one cycle after the data drive starts.
- R8: Acknowledge rises only after a request and stays high until request is seen low, then drops on the next clock.
- R9: Received bytes are checked for odd parity over the eight data bits plus the parity line; `par_err` is high together with `rx_valid` on a mismatch.
- R10: `atn_out` follows `atn_req` from the start of selection until the connection ends, and is low otherwise.
- R11: When the target drops busy while connected, `done` pulses for one cycle and the controller returns to IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a connection attempt (sampled in IDLE) |
| tgt_id | input | ID_W | Target ID to select |
| atn_req | input | 1 | Request attention toward the target |
| out_data | input | 8 | Next byte to send to the target |
| out_take | output | 1 | Pulse: `out_data` was latched |
| rx_valid | output | 1 | Pulse: `rx_byte` holds a received byte |
| rx_byte | output | 8 | Received byte |
| rx_phase | output | 3 | Phase of the received byte {cd,msg,io} |
| par_err | output | 1 | Parity mismatch on the received byte |
| arb_lost | output | 1 | Pulse: arbitration lost |
| sel_fail | output | 1 | Pulse: selection timed out |
| done | output | 1 | Pulse: connection ended |
| ctl_busy | output | 1 | Controller not in IDLE |
| bus_db_in | input | 8 | Observed data lines |
| bus_dbp_in | input | 1 | Observed parity line |
| bus_bsy_in | input | 1 | Observed busy line |
| bus_sel_in | input | 1 | Observed select line |
| bus_req_in | input | 1 | Observed request line |
| bus_cd_in | input | 1 | Observed control/data line |
| bus_msg_in | input | 1 | Observed message line |
| bus_io_in | input | 1 | Observed input/output line |
| bus_rst_in | input | 1 | Observed bus reset line |
| db_out | output | 8 | Data line drive value |
| dbp_out | output | 1 | Parity line drive value |
| db_oe | output | 1 | Data and parity drive enable |
| bsy_out | output | 1 | Busy drive |
| sel_out | output | 1 | Select drive |
| ack_out | output | 1 | Acknowledge drive |
| atn_out | output | 1 | Attention drive |

## Verification
The target model runs a command phase and then input-direction data, status and message phases, so both the capture path and the drive path are exercised with several byte values. Bytes 0x00, 0xFF and alternating patterns tell a wrong parity polarity apart from a correct one, and one byte is sent with deliberately wrong parity. A competing device with a higher ID shows whether the controller withdraws and retries rather than selecting. A pre-held busy line pins down the exact free-bus count. A missing target and a mid-selection bus reset separate the timeout exit from the abort exit.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WAIT_FREE,
        ST_ARB,
        ST_LOST,
        ST_SEL_DRIVE,
        ST_SEL_WAIT,
        ST_SEL_FAIL,
        ST_XFER,
        ST_CAPT,
        ST_ACK_IN,
        ST_DRIVE,
        ST_ACK_OUT,
        ST_DONE
    } ctl_state_t;

    typedef struct packed {
        logic cd;
        logic msg;
        logic io;
    } phase_t;

endpackage

// File: rtl/pbus_timer.sv
module pbus_timer #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    output logic [W-1:0] count
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (count != {W{1'b1}}) begin
            count <= count + W'(1);
        end
    end

endmodule

// File: rtl/pbus_arb_judge.sv
module pbus_arb_judge #(
    parameter int DB_W   = 8,
    parameter int OWN_ID = 6
) (
    input  logic [DB_W-1:0] lines,
    output logic            higher
);

    localparam logic [DB_W-1:0] AT_OR_BELOW = (DB_W'(2) << OWN_ID) - DB_W'(1);
    localparam logic [DB_W-1:0] ABOVE_MASK  = ~AT_OR_BELOW;

    assign higher = |(lines & ABOVE_MASK);

endmodule

// File: rtl/pbus_parity.sv
module pbus_parity #(
    parameter int W = 8
) (
    input  logic [W-1:0] data,
    output logic         odd_bit
);

    assign odd_bit = ~^data;

endmodule

// File: rtl/pbus_initiator.sv
module pbus_initiator
    import pbus_pkg::*;
#(
    parameter int ID_W     = 3,
    parameter int OWN_ID   = 6,
    parameter int FREE_CYC = 4,
    parameter int ARB_CYC  = 3,
    parameter int SEL_TMO  = 64,
    localparam int DB_W    = 1 << ID_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [ID_W-1:0] tgt_id,
    input  logic            atn_req,
    input  logic [DB_W-1:0] out_data,
    output logic            out_take,
    output logic            rx_valid,
    output logic [DB_W-1:0] rx_byte,
    output logic [2:0]      rx_phase,
    output logic            par_err,
    output logic            arb_lost,
    output logic            sel_fail,
    output logic            done,
    output logic            ctl_busy,
    input  logic [DB_W-1:0] bus_db_in,
    input  logic            bus_dbp_in,
    input  logic            bus_bsy_in,
    input  logic            bus_sel_in,
    input  logic            bus_req_in,
    input  logic            bus_cd_in,
    input  logic            bus_msg_in,
    input  logic            bus_io_in,
    input  logic            bus_rst_in,
    output logic [DB_W-1:0] db_out,
    output logic            dbp_out,
    output logic            db_oe,
    output logic            bsy_out,
    output logic            sel_out,
    output logic            ack_out,
    output logic            atn_out
);

    localparam int T_A    = (FREE_CYC > ARB_CYC) ? FREE_CYC : ARB_CYC;
    localparam int T_MAX  = (T_A > SEL_TMO) ? T_A : SEL_TMO;
    localparam int TMR_W  = $clog2(T_MAX + 1);
    localparam logic [TMR_W-1:0] FREE_LAST = TMR_W'(FREE_CYC - 1);
    localparam logic [TMR_W-1:0] ARB_LAST  = TMR_W'(ARB_CYC - 1);
    localparam logic [TMR_W-1:0] SEL_LAST  = TMR_W'(SEL_TMO - 1);
    localparam logic [DB_W-1:0]  OWN_BIT   = DB_W'(1) << OWN_ID;

    ctl_state_t state_q, state_d;
    logic [ID_W-1:0]  tgt_q;
    logic [DB_W-1:0]  tx_q;
    logic [DB_W-1:0]  rx_q;
    phase_t           rx_ph_q;
    logic             rx_bad_q;
    logic [TMR_W-1:0] tcnt;
    logic             bus_free;
    logic             tmr_clear;
    logic             higher_seen;
    logic             tx_par;
    logic             rx_par_exp;
    logic [DB_W-1:0]  sel_pattern;

    assign bus_free    = !bus_bsy_in && !bus_sel_in;
    assign tmr_clear   = (state_q != state_d) || ((state_q == ST_WAIT_FREE) && !bus_free);
    assign sel_pattern = OWN_BIT | (DB_W'(1) << tgt_q);

    pbus_timer #(.W(TMR_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (tmr_clear),
        .count (tcnt)
    );

    pbus_arb_judge #(.DB_W(DB_W), .OWN_ID(OWN_ID)) u_judge (
        .lines  (bus_db_in),
        .higher (higher_seen)
    );

    pbus_parity #(.W(DB_W)) u_tx_par (
        .data    (tx_q),
        .odd_bit (tx_par)
    );

    pbus_parity #(.W(DB_W)) u_rx_par (
        .data    (bus_db_in),
        .odd_bit (rx_par_exp)
    );

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = ST_WAIT_FREE;
            end
            ST_WAIT_FREE: begin
                if (bus_free && (tcnt == FREE_LAST)) state_d = ST_ARB;
            end
            ST_ARB: begin
                if (bus_sel_in) begin
                    state_d = ST_LOST;
                end else if (tcnt == ARB_LAST) begin
                    state_d = higher_seen ? ST_LOST : ST_SEL_DRIVE;
                end
            end
            ST_LOST:      state_d = ST_WAIT_FREE;
            ST_SEL_DRIVE: state_d = ST_SEL_WAIT;
            ST_SEL_WAIT: begin
                if (bus_bsy_in) begin
                    state_d = ST_XFER;
                end else if (tcnt == SEL_LAST) begin
                    state_d = ST_SEL_FAIL;
                end
            end
            ST_SEL_FAIL:  state_d = ST_IDLE;
            ST_XFER: begin
                if (!bus_bsy_in) begin
                    state_d = ST_DONE;
                end else if (bus_req_in) begin
                    state_d = bus_io_in ? ST_CAPT : ST_DRIVE;
                end
            end
            ST_CAPT:      state_d = ST_ACK_IN;
            ST_ACK_IN: begin
                if (!bus_req_in) state_d = ST_XFER;
            end
            ST_DRIVE:     state_d = ST_ACK_OUT;
            ST_ACK_OUT: begin
                if (!bus_req_in) state_d = ST_XFER;
            end
            ST_DONE:      state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
        if (bus_rst_in) state_d = ST_IDLE;
    end

    // state register and byte holding registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            tgt_q    <= '0;
            tx_q     <= '0;
            rx_q     <= '0;
            rx_ph_q  <= '0;
            rx_bad_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if ((state_q == ST_IDLE) && start) begin
                tgt_q <= tgt_id;
            end
            if ((state_q == ST_XFER) && (state_d == ST_CAPT)) begin
                rx_q     <= bus_db_in;
                rx_ph_q  <= '{cd: bus_cd_in, msg: bus_msg_in, io: bus_io_in};
                rx_bad_q <= (bus_dbp_in != rx_par_exp);
            end
            if ((state_q == ST_XFER) && (state_d == ST_DRIVE)) begin
                tx_q <= out_data;
            end
        end
    end

    // outputs decoded from the current state
    always_comb begin
        bsy_out  = 1'b0;
        sel_out  = 1'b0;
        db_oe    = 1'b0;
        db_out   = '0;
        dbp_out  = 1'b0;
        ack_out  = 1'b0;
        atn_out  = 1'b0;
        out_take = 1'b0;
        rx_valid = 1'b0;
        par_err  = 1'b0;
        arb_lost = 1'b0;
        sel_fail = 1'b0;
        done     = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_WAIT_FREE: ;
            ST_ARB: begin
                bsy_out = 1'b1;
                db_oe   = 1'b1;
                db_out  = OWN_BIT;
            end
            ST_LOST:  arb_lost = 1'b1;
            ST_SEL_DRIVE: begin
                bsy_out = 1'b1;
                sel_out = 1'b1;
                db_oe   = 1'b1;
                db_out  = sel_pattern;
                atn_out = atn_req;
            end
            ST_SEL_WAIT: begin
                sel_out = 1'b1;
                db_oe   = 1'b1;
                db_out  = sel_pattern;
                atn_out = atn_req;
            end
            ST_SEL_FAIL: sel_fail = 1'b1;
            ST_XFER:  atn_out = atn_req;
            ST_CAPT: begin
                ack_out  = 1'b1;
                rx_valid = 1'b1;
                par_err  = rx_bad_q;
                atn_out  = atn_req;
            end
            ST_ACK_IN: begin
                ack_out = 1'b1;
                atn_out = atn_req;
            end
            ST_DRIVE: begin
                db_oe    = 1'b1;
                db_out   = tx_q;
                dbp_out  = tx_par;
                out_take = 1'b1;
                atn_out  = atn_req;
            end
            ST_ACK_OUT: begin
                db_oe   = 1'b1;
                db_out  = tx_q;
                dbp_out = tx_par;
                ack_out = 1'b1;
                atn_out = atn_req;
            end
            ST_DONE:  done = 1'b1;
            default: ;
        endcase
    end

    assign rx_byte  = rx_q;
    assign rx_phase = rx_ph_q;
    assign ctl_busy = (state_q != ST_IDLE);

endmodule

// File: rtl/pbus_initiator_chk.sv
module pbus_initiator_chk #(
    parameter int DB_W   = 8,
    parameter int OWN_ID = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            bsy_out,
    input logic            sel_out,
    input logic            db_oe,
    input logic [DB_W-1:0] db_out,
    input logic            ack_out,
    input logic            bus_req_in,
    input logic            bus_bsy_in,
    input logic            bus_sel_in,
    input logic            bus_rst_in,
    input logic            done,
    input logic            arb_lost,
    input logic            sel_fail
);

    localparam logic [DB_W-1:0] OWN_BIT = DB_W'(1) << OWN_ID;

    // R1
    bus_reset_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst_in |=> (!bsy_out && !sel_out && !ack_out && !db_oe));

    // R2
    arb_after_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bsy_out) |-> $past(!bus_bsy_in && !bus_sel_in));

    // R3
    arb_own_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bsy_out && !sel_out) |-> (db_oe && (db_out == OWN_BIT)));

    // R4
    sel_ids_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_out && db_oe) |-> (db_out[OWN_ID] && ($countones(db_out) <= 2)));

    // R5
    sel_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_out && !bsy_out && bus_bsy_in) |=> (!sel_out && !db_oe));

    // R7
    out_data_settled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ack_out) && db_oe) |-> ($past(db_oe) && $stable(db_out)));

    // R8
    ack_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_out) |-> $past(bus_req_in));

    // R8
    ack_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_out) |-> $past(!bus_req_in || bus_rst_in));

    // R11
    done_after_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(!bus_bsy_in) && !bsy_out && !sel_out));

    // R3
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, arb_lost, sel_fail}));

endmodule

bind pbus_initiator pbus_initiator_chk #(
    .DB_W   (DB_W),
    .OWN_ID (OWN_ID)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bsy_out    (bsy_out),
    .sel_out    (sel_out),
    .db_oe      (db_oe),
    .db_out     (db_out),
    .ack_out    (ack_out),
    .bus_req_in (bus_req_in),
    .bus_bsy_in (bus_bsy_in),
    .bus_sel_in (bus_sel_in),
    .bus_rst_in (bus_rst_in),
    .done       (done),
    .arb_lost   (arb_lost),
    .sel_fail   (sel_fail)
);

// File: tb/pbus_initiator_test.sv
`timescale 1ns/1ps
module pbus_initiator_test;

    localparam int OWN = 6;
    localparam int TGT = 1;
    localparam int FREE_N = 4;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic       rst_n, start, atn_req, bus_rst;
    logic [2:0] tgt_id;
    logic [7:0] out_data;
    logic       out_take, rx_valid, par_err, arb_lost, sel_fail, done, ctl_busy;
    logic [7:0] rx_byte;
    logic [2:0] rx_phase;
    logic [7:0] db_out;
    logic       dbp_out, db_oe, bsy_out, sel_out, ack_out, atn_out;

    logic       t_bsy, t_req, t_cd, t_msg, t_io, t_db_oe, t_dbp;
    logic [7:0] t_db;
    logic       r_bsy;
    logic [7:0] r_db;

    logic [7:0] bus_db;
    logic       bus_dbp, bus_bsy;

    assign bus_db  = (db_oe ? db_out : 8'h00) | (t_db_oe ? t_db : 8'h00) | r_db;
    assign bus_dbp = (db_oe & dbp_out) | (t_db_oe & t_dbp);
    assign bus_bsy = bsy_out | t_bsy | r_bsy;

    pbus_initiator uut (
        .clk(clk), .rst_n(rst_n), .start(start), .tgt_id(tgt_id), .atn_req(atn_req),
        .out_data(out_data), .out_take(out_take), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rx_phase(rx_phase), .par_err(par_err), .arb_lost(arb_lost), .sel_fail(sel_fail),
        .done(done), .ctl_busy(ctl_busy),
        .bus_db_in(bus_db), .bus_dbp_in(bus_dbp), .bus_bsy_in(bus_bsy), .bus_sel_in(sel_out),
        .bus_req_in(t_req), .bus_cd_in(t_cd), .bus_msg_in(t_msg), .bus_io_in(t_io),
        .bus_rst_in(bus_rst),
        .db_out(db_out), .dbp_out(dbp_out), .db_oe(db_oe), .bsy_out(bsy_out),
        .sel_out(sel_out), .ack_out(ack_out), .atn_out(atn_out)
    );

    int total = 0;
    int bad = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // scoreboard state
    logic [11:0] exp_q[$];
    logic [11:0] exp_item;
    logic [7:0]  cmd_mem [4];
    logic [7:0]  din_mem [3];
    int          tx_idx, take_cnt, done_cnt, lost_cnt, fail_cnt;
    logic        atn_seen;
    logic [7:0]  sel_pat, arb_pat;

    assign out_data = cmd_mem[tx_idx[1:0]];

    // monitor: pops expected received bytes and tracks pulses
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            if (rx_valid) begin
                if (exp_q.size() == 0) begin
                    chk("R6 unexpected rx_valid", 1, 0);
                end else begin
                    exp_item = exp_q.pop_front();
                    chk("R6 received byte", rx_byte, exp_item[7:0]);
                    chk("R6 received phase", rx_phase, exp_item[10:8]);
                    chk("R9 parity flag", par_err, exp_item[11]);
                end
            end
            if (out_take) begin
                tx_idx++;
                take_cnt++;
            end
            if (done) done_cnt++;
            if (arb_lost) lost_cnt++;
            if (sel_fail) fail_cnt++;
            if (atn_out) atn_seen = 1'b1;
            if (sel_out && db_oe) sel_pat = db_out;
            if (bsy_out && !sel_out) arb_pat = db_oe ? db_out : 8'h00;
        end
    end

    task automatic wait_ack(input logic want);
        for (int i = 0; i < 50 && ack_out !== want; i++) @(negedge clk);
        chk("R8 acknowledge follows request", ack_out, want);
    endtask

    // target sends one byte toward the initiator
    task automatic send_in(input logic [7:0] b, input logic [2:0] ph, input logic badp);
        @(negedge clk);
        {t_cd, t_msg, t_io} = ph;
        t_db    = b;
        t_dbp   = (~^b) ^ badp;
        t_db_oe = 1'b1;
        exp_q.push_back({badp, ph, b});
        @(negedge clk);
        t_req = 1'b1;
        wait_ack(1'b1);
        repeat (2) @(negedge clk);
        chk("R8 ack held while request high", ack_out, 1);
        t_req = 1'b0;
        wait_ack(1'b0);
        t_db_oe = 1'b0;
    endtask

    // target takes one byte from the initiator
    task automatic recv_out(input logic [2:0] ph, input logic [7:0] expb);
        @(negedge clk);
        {t_cd, t_msg, t_io} = ph;
        t_db_oe = 1'b0;
        @(negedge clk);
        t_req = 1'b1;
        wait_ack(1'b1);
        chk("R7 byte driven to target", bus_db, expb);
        chk("R7 odd parity on driven byte", ^{bus_dbp, bus_db}, 1);
        t_req = 1'b0;
        wait_ack(1'b0);
    endtask

    task automatic run_target(input int n_cmd, input int base, input int bad_idx,
                              input logic [7:0] status);
        for (int i = 0; i < 500 && !(sel_out && bus_db[TGT] && !bsy_out); i++) @(negedge clk);
        chk("R4 selection seen by target", sel_out && bus_db[TGT] && !bsy_out, 1);
        t_bsy = 1'b1;
        @(negedge clk);
        chk("R5 select released", sel_out, 0);
        chk("R5 data lines released", db_oe, 0);
        for (int k = 0; k < n_cmd; k++) recv_out(3'b100, cmd_mem[base + k]);
        for (int k = 0; k < 3; k++) send_in(din_mem[k], 3'b001, (k == bad_idx));
        send_in(status, 3'b101, 1'b0);
        send_in(8'h00, 3'b111, 1'b0);
        @(negedge clk);
        {t_cd, t_msg, t_io} = 3'b000;
        t_bsy = 1'b0;
    endtask

    task automatic pulse_start(input logic [2:0] id);
        @(negedge clk);
        tgt_id = id;
        start  = 1'b1;
        @(negedge clk);
        start  = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; atn_req = 1'b0; bus_rst = 1'b0; tgt_id = '0;
        t_bsy = 1'b0; t_req = 1'b0; t_cd = 1'b0; t_msg = 1'b0; t_io = 1'b0;
        t_db_oe = 1'b0; t_dbp = 1'b0; t_db = '0; r_bsy = 1'b0; r_db = '0;
        tx_idx = 0; take_cnt = 0; done_cnt = 0; lost_cnt = 0; fail_cnt = 0;
        atn_seen = 1'b0; sel_pat = '0; arb_pat = '0;
        cmd_mem[0] = 8'h12; cmd_mem[1] = 8'h34; cmd_mem[2] = 8'h56; cmd_mem[3] = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 reset drives released", {bsy_out, sel_out, ack_out, db_oe, atn_out, ctl_busy}, 0);

        // transaction 1: bus held busy first, then a plain exchange
        din_mem[0] = 8'hA5; din_mem[1] = 8'h00; din_mem[2] = 8'hFF;
        t_bsy = 1'b1;
        pulse_start(3'(TGT));
        repeat (10) @(negedge clk);
        chk("R2 no busy while bus taken", bsy_out, 0);
        t_bsy = 1'b0;
        repeat (FREE_N - 1) @(negedge clk);
        chk("R2 still waiting for free count", bsy_out, 0);
        @(negedge clk);
        chk("R2 busy after free count", bsy_out, 1);
        run_target(2, 0, -1, 8'h00);
        repeat (4) @(negedge clk);
        chk("R11 done pulse count", done_cnt, 1);
        chk("R11 back to idle", ctl_busy, 0);
        chk("R3 arbitration pattern", arb_pat, 8'h40);
        chk("R4 selection pattern", sel_pat, 8'h42);
        chk("R7 bytes taken", take_cnt, 2);
        chk("R6 all bytes received", exp_q.size(), 0);
        chk("R10 attention idle when not requested", atn_seen, 0);
        chk("R3 no loss without rival", lost_cnt, 0);

        // transaction 2: higher-ID rival, attention, parity error
        din_mem[0] = 8'h3C; din_mem[1] = 8'h81; din_mem[2] = 8'h7E;
        tx_idx = 2;
        atn_req = 1'b1;
        pulse_start(3'(TGT));
        fork
            begin
                for (int i = 0; i < 200 && !bsy_out; i++) @(negedge clk);
                r_bsy = 1'b1;
                r_db  = 8'h80;
                repeat (12) @(negedge clk);
                chk("R3 withdrawn while rival holds bus", bsy_out | db_oe, 0);
                r_bsy = 1'b0;
                r_db  = 8'h00;
            end
            run_target(1, 2, 1, 8'h02);
        join
        repeat (4) @(negedge clk);
        chk("R3 one arbitration loss", lost_cnt, 1);
        chk("R10 attention raised", atn_seen, 1);
        chk("R10 attention dropped after end", atn_out, 0);
        chk("R11 done pulse count", done_cnt, 2);
        chk("R7 bytes taken", take_cnt, 3);
        chk("R6 all bytes received", exp_q.size(), 0);
        atn_req = 1'b0;

        // transaction 3: absent target, selection timeout
        pulse_start(3'd3);
        for (int i = 0; i < 200 && fail_cnt == 0; i++) @(negedge clk);
        chk("R4 selection timeout pulse", fail_cnt, 1);
        @(negedge clk);
        chk("R4 lines released after timeout", {bsy_out, sel_out, db_oe, ctl_busy}, 0);

        // transaction 4: bus reset during selection
        pulse_start(3'd3);
        for (int i = 0; i < 200 && !sel_out; i++) @(negedge clk);
        chk("R4 selection started", sel_out, 1);
        bus_rst = 1'b1;
        @(negedge clk);
        chk("R1 bus reset releases lines", {bsy_out, sel_out, ack_out, db_oe, ctl_busy}, 0);
        bus_rst = 1'b0;
        repeat (80) @(negedge clk);
        chk("R1 no timeout after bus reset", fail_cnt, 1);
        chk("R1 remains idle", ctl_busy, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule